// File: doc/BRIEF.md
# Codec Response Ring Writer

This block sits on the inbound side of an audio-link controller and takes each 32-bit codec response, which arrives with the sender's 4-bit codec address and a flag that marks it as unsolicited. A response can go to one of three places. If software has armed the single-shot immediate-response latch, the response lands there. If the ring engine is enabled, the response becomes an 8-byte entry in a 256-slot response ring in system memory. If neither applies, the response is thrown away.

Ring entries leave the block through a plain 32-bit memory write port as two words, one after the other. While those two words are in flight, the input handshake holds off the next response. The block counts the entries it writes and raises a ring interrupt status in two cases: when the count reaches a programmed threshold, or when the command ring has run dry. This coalesces interrupts. Clearing that status resets the count and sends a one-cycle resume pulse to the command fetcher, so the same threshold also paces how many commands are outstanding.

Software reaches the block through a small write-only configuration port. The block's state comes out on dedicated output ports.

Top module: `resp_ring_writer`

## Requirements
- R1: When the immediate busy flag (imm_stat bit 0) is set and a response is accepted, imm_data takes the response. In the same cycle busy clears, valid (bit 1) sets and bits 7:4 load the codec address. Writing cfg address 0 sets busy from data bit 0, and a 1 in data bit 1 clears valid.
- R2: When busy is clear and the DMA enable (cfg address 1, bit 1) is clear, an accepted response is dropped. No memory write happens and ring_wp and rsp_count stay unchanged.
- R3: A ring entry is written at base + 8*wp, where the base comes from cfg address 5 with its low 7 bits forced to zero. The response is written first. At address +4 the second word follows, carrying the codec address in bits 3:0, the unsolicited flag in bit 4 and zeros elsewhere.
- R4: The 8-bit write pointer is incremented before each entry is written and wraps from 255 to 0.
- R5: Each written entry increments rsp_count. When the new count equals the threshold (cfg address 3) and the interrupt enable (cfg address 1, bit 0) is on, ring_sts bit 0 sets.
- R6: When cmd_ring_empty is high as an entry completes and the interrupt enable is on, ring_sts bit 0 sets. With the enable off, no status is raised.
- R7: A write to cfg address 2 with bit 15 set clears the write pointer. The same write with bit 15 clear has no effect.
- R8: Writing cfg address 4 clears ring_sts bits 0 and 2 wherever the data has a 1 in that bit. Clearing a set bit 0 zeroes rsp_count and pulses fetch_resume for one cycle.
- R9: When an entry meets an interrupt condition while ring_sts bit 0 is already set, the overrun bit (ring_sts bit 2) sets.
- R10: irq_req is high exactly when ring_sts bit 0 or bit 2 is set.
- R11: rsp_ready stays low from acceptance until the second word is taken. While mem_ready is low, mem_we, mem_addr and mem_wdata hold steady.
- R12: After reset, ring_wp, rsp_count, ring_sts, imm_stat, irq_req and mem_we are 0, and rsp_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response accepted on this edge when valid |
| rsp_data | input | 32 | Codec response word |
| rsp_cad | input | 4 | Codec address of the sender |
| rsp_unsol | input | 1 | Response is unsolicited |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cmd_ring_empty | input | 1 | Command ring has no pending commands |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the current word |
| imm_data | output | 32 | Immediate response word |
| imm_stat | output | 8 | Immediate status: busy bit 0, valid bit 1, codec address bits 7:4 |
| ring_wp | output | 8 | Ring write pointer |
| ring_sts | output | 8 | Ring status: interrupt bit 0, overrun bit 2 |
| rsp_count | output | 8 | Responses written since the last interrupt clear |
| irq_req | output | 1 | Interrupt request toward the aggregator |
| fetch_resume | output | 1 | One-cycle pulse telling the command fetcher to continue |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of bug:
- Pointer wrap from 255 to 0: a pointer that is not pre-incremented, or that is wider than 8 bits, would put the entry at the wrong address.
- Threshold hit against the empty-ring trigger: a design that raises status with the enable off would show a spurious interrupt.
- A second trigger while status is already pending: without overrun detection, bit 2 would never set.
- A memory stall in the middle of an entry: a writer that moves on before mem_ready would change the address or data, or take a new response.
- Busy latch with the ring enabled: a design that ranks the ring above the latch would write memory instead of latching.
- Drop path: it must leave the pointer and counter alone.
- Bit-15 reset of the pointer: it must ignore the same write with the bit clear.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [2:0] {
    CFG_IMM  = 3'd0,
    CFG_CTL  = 3'd1,
    CFG_WP   = 3'd2,
    CFG_ICNT = 3'd3,
    CFG_STS  = 3'd4,
    CFG_BASE = 3'd5
  } cfg_sel_e;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_WORD0 = 2'd1,
    W_WORD1 = 2'd2
  } wr_state_e;

  localparam int CTL_IRQ_EN  = 0;
  localparam int CTL_DMA_EN  = 1;
  localparam int IMM_BUSY    = 0;
  localparam int IMM_VCLR    = 1;
  localparam int STS_INT     = 0;
  localparam int STS_OVR     = 2;
  localparam int WP_RST_BIT  = 15;
  localparam int BASE_ALIGN  = 7;
endpackage

// File: rtl/rr_imm_latch.sv
module rr_imm_latch #(
  parameter int DW    = 32,
  parameter int CAD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             wr_busy,
  input  logic             wr_vclr,
  input  logic             take,
  input  logic [DW-1:0]    rsp_data,
  input  logic [CAD_W-1:0] rsp_cad,
  output logic             busy,
  output logic             valid,
  output logic [CAD_W-1:0] cad,
  output logic [DW-1:0]    data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      valid <= 1'b0;
      cad   <= '0;
      data  <= '0;
    end else if (take) begin
      data  <= rsp_data;
      cad   <= rsp_cad;
      busy  <= 1'b0;
      valid <= 1'b1;
    end else if (cfg_wr) begin
      busy <= wr_busy;
      if (wr_vclr) valid <= 1'b0;
    end
  end

  // R1: a latched response clears busy, sets valid and keeps the word
  a_r1_imm_latch: assert property (@(posedge clk) disable iff (rst)
    take |=> (valid && !busy && data == $past(rsp_data) && cad == $past(rsp_cad)));
endmodule

// File: rtl/rr_ring_wr.sv
module rr_ring_wr
  import rr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PTR_W = 8,
  parameter int CAD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [DW-1:0]    rsp_data,
  input  logic [CAD_W-1:0] rsp_cad,
  input  logic             rsp_unsol,
  input  logic             imm_busy,
  input  logic             dma_en,
  input  logic [AW-1:0]    base,
  input  logic             wp_clear,
  output logic             imm_take,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  output logic [PTR_W-1:0] wp,
  output logic             entry_done
);
  localparam int WORD_B = DW / 8;
  localparam int ESH    = $clog2(2 * WORD_B);

  wr_state_e        state;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    w0_q, w1_q;
  logic             accept, ring_go;
  logic [PTR_W-1:0] wp_next;

  assign rsp_ready  = (state == W_IDLE);
  assign accept     = rsp_valid && rsp_ready;
  assign imm_take   = accept && imm_busy;
  assign ring_go    = accept && !imm_busy && dma_en;
  assign wp_next    = wp + PTR_W'(1);
  assign mem_we     = (state != W_IDLE);
  assign mem_addr   = addr_q;
  assign mem_wdata  = (state == W_WORD1) ? w1_q : w0_q;
  assign entry_done = (state == W_WORD1) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= W_IDLE;
      wp     <= '0;
      addr_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
    end else begin
      case (state)
        W_IDLE: if (ring_go) begin
          wp     <= wp_next;
          addr_q <= base + (AW'(wp_next) << ESH);
          w0_q   <= rsp_data;
          w1_q   <= DW'({rsp_unsol, rsp_cad});
          state  <= W_WORD0;
        end
        W_WORD0: if (mem_ready) begin
          addr_q <= addr_q + AW'(WORD_B);
          state  <= W_WORD1;
        end
        W_WORD1: if (mem_ready) state <= W_IDLE;
        default: state <= W_IDLE;
      endcase
      if (wp_clear) wp <= '0;
    end
  end

  // R11: a stalled word holds address and data
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));
  // R3: second word sits one word above the first
  a_r3_word_step: assert property (@(posedge clk) disable iff (rst)
    (state == W_WORD0 && mem_ready) |=> (mem_we && mem_addr == $past(mem_addr) + AW'(WORD_B)));
  // R4: pointer advances by exactly one per ring entry
  a_r4_wp_step: assert property (@(posedge clk) disable iff (rst)
    (ring_go && !wp_clear) |=> (wp == $past(wp) + PTR_W'(1)));
endmodule

// File: rtl/rr_coalesce.sv
module rr_coalesce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entry_done,
  input  logic             cmd_empty,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] icnt,
  input  logic             clr_int,
  input  logic             clr_ovr,
  output logic             int_q,
  output logic             ovr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_req,
  output logic             fetch_resume
);
  logic             int_n, ovr_n, resume_n;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    int_n    = int_q;
    ovr_n    = ovr_q;
    cnt_n    = cnt_q;
    resume_n = 1'b0;
    if (clr_int && int_q) begin
      int_n    = 1'b0;
      cnt_n    = '0;
      resume_n = 1'b1;
    end
    if (clr_ovr) ovr_n = 1'b0;
    if (entry_done) begin
      cnt_n = cnt_n + CNT_W'(1);
      if (irq_en && (cnt_n == icnt || cmd_empty)) begin
        if (int_q) ovr_n = 1'b1;
        int_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q        <= 1'b0;
      ovr_q        <= 1'b0;
      cnt_q        <= '0;
      irq_req      <= 1'b0;
      fetch_resume <= 1'b0;
    end else begin
      int_q        <= int_n;
      ovr_q        <= ovr_n;
      cnt_q        <= cnt_n;
      irq_req      <= int_n | ovr_n;
      fetch_resume <= resume_n;
    end
  end

  // R5: reaching the threshold with the enable on raises status
  a_r5_count_hit: assert property (@(posedge clk) disable iff (rst)
    (entry_done && irq_en && !clr_int && (cnt_q + CNT_W'(1) == icnt)) |=> int_q);
  // R6: with the enable off an entry never raises status
  a_r6_no_irq_off: assert property (@(posedge clk) disable iff (rst)
    (entry_done && !irq_en && !clr_int) |=> (int_q == $past(int_q)));
  // R8: the resume pulse follows a counter clear
  a_r8_resume: assert property (@(posedge clk) disable iff (rst)
    fetch_resume |-> (cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
  import rr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PTR_W = 8,
  parameter int CAD_W = 4,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [DW-1:0]      rsp_data,
  input  logic [CAD_W-1:0]   rsp_cad,
  input  logic               rsp_unsol,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic               cmd_ring_empty,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_ready,
  output logic [DW-1:0]      imm_data,
  output logic [CAD_W+3:0]   imm_stat,
  output logic [PTR_W-1:0]   ring_wp,
  output logic [7:0]         ring_sts,
  output logic [CNT_W-1:0]   rsp_count,
  output logic               irq_req,
  output logic               fetch_resume
);
  cfg_sel_e         sel;
  logic [1:0]       ctl_q;
  logic [CNT_W-1:0] icnt_q;
  logic [AW-1:0]    base_q;
  logic             imm_busy, imm_valid, imm_take, entry_done;
  logic [CAD_W-1:0] imm_cad;
  logic             int_q, ovr_q;

  assign sel = cfg_sel_e'(cfg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      icnt_q <= '0;
      base_q <= '0;
    end else if (cfg_we) begin
      case (sel)
        CFG_CTL:  ctl_q  <= cfg_wdata[1:0];
        CFG_ICNT: icnt_q <= cfg_wdata[CNT_W-1:0];
        CFG_BASE: base_q <= {cfg_wdata[AW-1:BASE_ALIGN], BASE_ALIGN'(0)};
        default: ;
      endcase
    end
  end

  rr_imm_latch #(.DW(DW), .CAD_W(CAD_W)) u_imm (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_we && sel == CFG_IMM),
    .wr_busy(cfg_wdata[IMM_BUSY]), .wr_vclr(cfg_wdata[IMM_VCLR]),
    .take(imm_take), .rsp_data(rsp_data), .rsp_cad(rsp_cad),
    .busy(imm_busy), .valid(imm_valid), .cad(imm_cad), .data(imm_data)
  );

  rr_ring_wr #(.AW(AW), .DW(DW), .PTR_W(PTR_W), .CAD_W(CAD_W)) u_wr (
    .clk(clk), .rst(rst),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_cad(rsp_cad), .rsp_unsol(rsp_unsol),
    .imm_busy(imm_busy), .dma_en(ctl_q[CTL_DMA_EN]), .base(base_q),
    .wp_clear(cfg_we && sel == CFG_WP && cfg_wdata[WP_RST_BIT]),
    .imm_take(imm_take),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .wp(ring_wp), .entry_done(entry_done)
  );

  rr_coalesce #(.CNT_W(CNT_W)) u_coal (
    .clk(clk), .rst(rst),
    .entry_done(entry_done), .cmd_empty(cmd_ring_empty),
    .irq_en(ctl_q[CTL_IRQ_EN]), .icnt(icnt_q),
    .clr_int(cfg_we && sel == CFG_STS && cfg_wdata[STS_INT]),
    .clr_ovr(cfg_we && sel == CFG_STS && cfg_wdata[STS_OVR]),
    .int_q(int_q), .ovr_q(ovr_q), .cnt_q(rsp_count),
    .irq_req(irq_req), .fetch_resume(fetch_resume)
  );

  assign imm_stat = {imm_cad, 2'b00, imm_valid, imm_busy};
  assign ring_sts = {5'b0, ovr_q, 1'b0, int_q};
endmodule

// File: tb/test_resp_ring_writer.sv
`timescale 1ns/1ps
module test_resp_ring_writer;
  localparam logic [31:0] BASE = 32'h0001_2080;

  // {data, cad, unsol}
  localparam logic [36:0] VEC [6] = '{
    {32'h1234_5678, 4'h0, 1'b0},
    {32'hDEAD_BEEF, 4'h3, 1'b1},
    {32'h0000_0000, 4'hF, 1'b0},
    {32'hFFFF_FFFF, 4'h7, 1'b1},
    {32'hA5A5_5A5A, 4'hE, 1'b0},
    {32'h0F0F_F0F0, 4'h1, 1'b1}
  };

  logic        clk = 0, rst = 1;
  logic        rsp_valid = 0, rsp_unsol = 0, cfg_we = 0, cmd_ring_empty = 0, mem_ready = 1;
  logic [31:0] rsp_data = 0, cfg_wdata = 0;
  logic [3:0]  rsp_cad = 0;
  logic [2:0]  cfg_addr = 0;
  logic        rsp_ready, mem_we, irq_req, fetch_resume;
  logic [31:0] mem_addr, mem_wdata, imm_data;
  logic [7:0]  imm_stat, ring_wp, ring_sts, rsp_count;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  resp_ring_writer i_resp_ring_writer (
    .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_cad(rsp_cad), .rsp_unsol(rsp_unsol),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cmd_ring_empty(cmd_ring_empty), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .imm_data(imm_data),
    .imm_stat(imm_stat), .ring_wp(ring_wp), .ring_sts(ring_sts),
    .rsp_count(rsp_count), .irq_req(irq_req), .fetch_resume(fetch_resume)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic push(input logic [31:0] d, input logic [3:0] c, input logic u);
    @(negedge clk); rsp_valid = 1; rsp_data = d; rsp_cad = c; rsp_unsol = u;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic push_ring(input logic [31:0] d, input logic [3:0] c, input logic u,
                           input logic [7:0] exp_wp);
    push(d, c, u);
    chk("R3 word0 we", {31'b0, mem_we}, 32'd1);
    chk("R3/R4 word0 addr", mem_addr, BASE + 32'(exp_wp) * 8);
    chk("R3 word0 data", mem_wdata, d);
    @(negedge clk);
    chk("R3 word1 addr", mem_addr, BASE + 32'(exp_wp) * 8 + 4);
    chk("R3 word1 data", mem_wdata, {27'b0, u, c});
    @(negedge clk);
    chk("R4 wp", {24'b0, ring_wp}, {24'b0, exp_wp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 wp", {24'b0, ring_wp}, 0);
    chk("R12 sts", {24'b0, ring_sts}, 0);
    chk("R12 count", {24'b0, rsp_count}, 0);
    chk("R12 imm_stat", {24'b0, imm_stat}, 0);
    chk("R12 irq/we/ready", {29'b0, irq_req, mem_we, rsp_ready}, 32'd1);

    cfg(3'd5, BASE | 32'h7F);   // low bits must be dropped
    cfg(3'd1, 32'h2);           // DMA only
    cfg(3'd3, 32'hF0);
    for (int i = 0; i < 6; i++) begin
      push_ring(VEC[i][36:5], VEC[i][4:1], VEC[i][0], 8'(i + 1));
      chk("R5 count", {24'b0, rsp_count}, i + 1);
      chk("R6 no sts with irq off", {24'b0, ring_sts}, 0);
    end

    // R5 threshold
    cfg(3'd1, 32'h3);
    cfg(3'd3, 32'd8);
    push_ring(32'h1111_0007, 4'h2, 0, 8'd7);
    chk("R5 below threshold", {24'b0, ring_sts}, 0);
    push_ring(32'h1111_0008, 4'h2, 0, 8'd8);
    chk("R5 threshold sts", {24'b0, ring_sts}, 32'h01);
    chk("R10 irq_req on int", {31'b0, irq_req}, 1);

    // R9 overrun
    push_ring(32'h1111_0009, 4'h2, 0, 8'd9);
    chk("R9 no overrun without trigger", {24'b0, ring_sts}, 32'h01);
    cmd_ring_empty = 1;
    push_ring(32'h1111_000A, 4'h2, 0, 8'd10);
    chk("R9 overrun", {24'b0, ring_sts}, 32'h05);

    // R8 clear
    cfg(3'd4, 32'h1);
    chk("R8 int cleared", {24'b0, ring_sts}, 32'h04);
    chk("R8 count zero", {24'b0, rsp_count}, 0);
    chk("R8 resume pulse", {31'b0, fetch_resume}, 1);
    chk("R10 irq on ovr", {31'b0, irq_req}, 1);
    @(negedge clk);
    chk("R8 resume one cycle", {31'b0, fetch_resume}, 0);
    cfg(3'd4, 32'h4);
    chk("R8 ovr cleared", {24'b0, ring_sts}, 0);
    chk("R10 irq low", {31'b0, irq_req}, 0);

    // R6 empty trigger
    push_ring(32'h2222_0001, 4'h4, 1, 8'd11);
    chk("R6 empty trigger", {24'b0, ring_sts}, 32'h01);
    cfg(3'd4, 32'h1);
    cfg(3'd1, 32'h2);
    push_ring(32'h2222_0002, 4'h4, 1, 8'd12);
    chk("R6 enable off", {24'b0, ring_sts}, 0);
    chk("R5 count after clear", {24'b0, rsp_count}, 1);

    // R7 pointer reset
    cfg(3'd2, 32'h0000_7FFF);
    chk("R7 bit15 clear ignored", {24'b0, ring_wp}, 12);
    cfg(3'd2, 32'h0000_8000);
    chk("R7 reset", {24'b0, ring_wp}, 0);

    // R4 wrap
    cmd_ring_empty = 0;
    for (int i = 0; i < 255; i++) push(32'(i), 4'h0, 0);
    repeat (2) @(negedge clk);
    chk("R4 wp at 255", {24'b0, ring_wp}, 255);
    push_ring(32'h3333_0000, 4'h9, 0, 8'd0);

    // R2 drop
    cfg(3'd1, 32'h0);
    push(32'h4444_0000, 4'h1, 0);
    chk("R2 no write", {31'b0, mem_we}, 0);
    @(negedge clk);
    chk("R2 still no write", {31'b0, mem_we}, 0);
    chk("R2 wp kept", {24'b0, ring_wp}, 0);

    // R1 immediate latch, takes priority over ring
    cfg(3'd1, 32'h2);
    cfg(3'd0, 32'h1);
    chk("R1 busy set", {24'b0, imm_stat}, 32'h01);
    push(32'hCAFE_0001, 4'h5, 0);
    chk("R1 imm data", imm_data, 32'hCAFE_0001);
    chk("R1 imm stat", {24'b0, imm_stat}, 32'h52);
    chk("R1 no ring write", {31'b0, mem_we}, 0);
    cfg(3'd0, 32'h2);
    chk("R1 valid cleared", {24'b0, imm_stat}, 32'h50);

    // R11 stall
    mem_ready = 0;
    push_ring_stall();
    chk("R11 wp single step", {24'b0, ring_wp}, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic push_ring_stall();
    push(32'h5555_AAAA, 4'h6, 1);
    chk("R11 ready low", {31'b0, rsp_ready}, 0);
    rsp_valid = 1; rsp_data = 32'h9999_9999;
    repeat (3) @(negedge clk);
    chk("R11 held we", {31'b0, mem_we}, 1);
    chk("R11 held addr", mem_addr, BASE + 8);
    chk("R11 held data", mem_wdata, 32'h5555_AAAA);
    chk("R11 no accept", {31'b0, rsp_ready}, 0);
    rsp_valid = 0;
    mem_ready = 1;
    @(negedge clk);
    chk("R11 word1", mem_wdata, 32'h0000_0016);
    @(negedge clk);
    chk("R11 idle", {30'b0, mem_we, rsp_ready}, 32'd1);
  endtask
endmodule